// File: doc/BRIEF.md
# Jointly scaling profile counters

This block keeps four 32-bit utilisation counters for a radio MAC: transmit time, receive time, channel-busy time and total elapsed cycles. The cycle counter advances on every clock that is not frozen. The other three advance only on clocks where their activity input is high. Software divides one counter by the cycle counter to get a duty ratio, for example air-time or channel load.

The counters never wrap and never saturate. A counter may sit at all-ones while its input asks for one more count. On that clock every counter in the group is halved, and the pending increments are kept at half weight. The ratios between the counters therefore stay correct. The group shares a freeze control and a clear control with the other statistics, and it raises no interrupt. A combinational read port returns one counter, chosen by a 2-bit select.

Top module: `prof_ratio_counters`

## Requirements
- R1: After reset all four counters read 0.
- R2: On every clock with freeze low and clear low, the cycle counter (read select 3) advances.
- R3: The transmit counter (select 0), the receive counter (select 1) and the busy counter (select 2) each add 1 only on clocks where `tx_act`, `rx_act` or `busy_act`, respectively, is high. When its input is low, the counter does not change, unless a halving or a clear occurs.
- R4: When `clear` is high, all four counters are 0 on the next clock. This holds whatever the state of `freeze`, the activity inputs or a pending halving.
- R5: When `freeze` is high and `clear` is low, no counter changes: there is no increment and no halving.
- R6: A halving clock is an unfrozen clock where some counter is all-ones and its increment is 1. On that clock every counter takes (value + increment) >> 1. No counter ever wraps to a small value.
- R7: `rd_data` shows the counter chosen by `rd_sel` in the same cycle. The encoding is 0 = transmit, 1 = receive, 2 = busy, 3 = cycle. Reading has no effect on any counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Hold all counters |
| clear | input | 1 | Zero all counters, highest priority |
| tx_act | input | 1 | Transmitter active this cycle |
| rx_act | input | 1 | Receiver active this cycle |
| busy_act | input | 1 | Channel sensed busy this cycle |
| rd_sel | input | 2 | Counter select for the read port |
| rd_data | output | W | Selected counter value |

## Verification
The bench builds the block with an 8-bit width, so that halving is reached within a few hundred clocks. It applies idle inputs, fixed inputs and interleaved patterns of different periods on the three activity inputs. A wrong input-to-counter mapping, or a counter that lags the cycle counter, then shows up as a numeric mismatch. It also freezes the block while the inputs keep toggling, and clears it while it is frozen. It then runs past full scale several times, so that a halving which drops or doubles the pending increment, or which leaves some counters unscaled, differs from the model.

// File: rtl/prof_ratio_counters.sv
module prof_ratio_counters #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic         clear,
  input  logic         tx_act,
  input  logic         rx_act,
  input  logic         busy_act,
  input  logic [1:0]   rd_sel,
  output logic [W-1:0] rd_data
);
  localparam int N = 4;

  logic [N-1:0][W-1:0] cnt;
  logic [N-1:0][W:0]   sum;
  logic [N-1:0]        inc, carry;
  logic                halve;

  assign inc = {1'b1, busy_act, rx_act, tx_act};

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign sum[g]   = {1'b0, cnt[g]} + (W+1)'(inc[g]);
    assign carry[g] = sum[g][W];
  end

  assign halve = |carry;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else if (!freeze) begin
      for (int i = 0; i < N; i++)
        cnt[i] <= halve ? sum[i][W:1] : sum[i][W-1:0];
    end
  end

  assign rd_data = cnt[rd_sel];

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0); // R4
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clear) |=> $stable(cnt)); // R5
  AST_CYCLE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !clear && !(&cnt[3])) |=> cnt[3] != $past(cnt[3])); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !clear && &cnt[3]) |=> cnt[3] == {1'b1, {(W-1){1'b0}}}); // R6
  AST_CYCLE_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[3] >= cnt[0]) && (cnt[3] >= cnt[1]) && (cnt[3] >= cnt[2])); // R3
endmodule

// File: tb/sim_prof_ratio_counters.sv
module sim_prof_ratio_counters;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0, freeze = 0, clear = 0;
  logic tx_act = 0, rx_act = 0, busy_act = 0;
  logic [1:0] rd_sel = 0;
  logic [W-1:0] rd_data;

  int checks = 0, failures = 0;
  int m [4];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prof_ratio_counters #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .clear(clear),
    .tx_act(tx_act), .rx_act(rx_act), .busy_act(busy_act),
    .rd_sel(rd_sel), .rd_data(rd_data));

  task automatic compare(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd_sel = 2'(i);
      #1;
      checks++;
      if (int'(rd_data) != m[i]) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", tag, i, rd_data, m[i]);
      end
    end
  endtask

  task automatic step(input bit t, input bit r, input bit b,
                      input bit frz, input bit clr, input string tag);
    int incv [4];
    bit any;
    tx_act = t; rx_act = r; busy_act = b; freeze = frz; clear = clr;
    @(posedge clk);
    incv[0] = t; incv[1] = r; incv[2] = b; incv[3] = 1;
    if (clr) begin
      for (int i = 0; i < 4; i++) m[i] = 0;
    end else if (!frz) begin
      any = 0;
      for (int i = 0; i < 4; i++) if (m[i] == MAXV && incv[i] == 1) any = 1;
      for (int i = 0; i < 4; i++) m[i] = any ? (m[i] + incv[i]) / 2 : m[i] + incv[i];
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 30; k++) step(k % 2 == 0, 1, k % 3 == 0, 0, 0, "R3");
    for (int k = 0; k < 12; k++) step(1, 1, 1, 1, 0, "R5");
    compare("R7");
    compare("R7");
    step(1, 1, 1, 1, 1, "R4");
    for (int k = 0; k < 40; k++) step(1, k % 2 == 1, k % 4 == 0, 0, 0, "R3");
    step(1, 1, 1, 0, 1, "R4");
    for (int k = 0; k < 700; k++) step(1, k % 2 == 0, k % 5 != 0, 0, 0, "R6");
    for (int k = 0; k < 300; k++) begin
      if (m[3] == MAXV) begin
        step(1, 1, 1, 1, 0, "R5");
        step(1, 1, 1, 0, 1, "R4");
        break;
      end
      step(1, 1, k % 3 == 0, 0, 0, "R6");
    end
    for (int k = 0; k < 600; k++) step(k % 7 != 0, k % 3 == 0, 1, k % 50 == 0, 0, "R6");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule